// File: doc/BRIEF.md
# Session Key and Voice Mask Sequencer

This block sequences an external mixing engine to turn the state left behind by an authentication run into an 8-byte session key and a 520-bit duplex voice mask. When started, it builds the first load for the engine from the 64-bit secret, a fixed version byte, a 24-bit identity field (with dialed digits optionally written over it) and the 32-bit serial number. It then issues fourteen chained engine runs. Before every run after the first it reloads only the engine's 32-bit LFSR, taking it from bytes of the previous result. The mixing registers and both table offsets stay inside the engine and carry over from run to run.

Results are taken from fixed pairs of result bytes. The second and third runs give the key. Runs four to fourteen fill a 65-byte mask buffer. That buffer is read as two 260-bit masks: the mobile-transmit mask and the mobile-receive mask. The split between them falls inside one byte. Each mask is read one bit at a time through an index port. Both masks read as zero until the whole mask exists, and they are frozen from then until reset.

Requests to the engine use a valid/ready handshake. While `eng_req_valid` is high and `eng_req_ready` is low, the request is held and every payload field stays stable. The transfer happens on the first edge where both are high. Responses carry no back-pressure: the sequencer accepts `eng_rsp_valid` on any cycle while it is waiting for a result. The engine must raise it for one cycle per accepted request.

Top module: `kms_top`

## Requirements
- R1: The first request has `eng_req_load_regs`=1 and `eng_req_rounds`=8. Register byte Rn sits at `eng_req_regs[8n+7:8n]`. R0..R7 hold the secret, with R0 taking bits 63:56. R8 holds 0xC7. R9..R11 hold the identity field, with R9 taking bits 23:16. R12..R15 hold the serial number, with R12 taking bits 31:24. The LFSR is `post_lfsr ^ secret[63:32] ^ secret[31:0]`.
- R2: If that first LFSR value is zero, `challenge` is sent instead.
- R3: With `orig_mode`=1, the first min(`dial_cnt`,6) digits overwrite nibbles of {R9,R10,R11}. Digit k is `dial_digits[4k+3:4k]`, where digit 0 is the last one dialed. Digit k goes to nibble k, counted upward from the low nibble of R11. With `orig_mode`=0 the digits have no effect.
- R4: Every later request has `eng_req_load_regs`=0 and `eng_req_rounds`=4. Its LFSR is {R0,R1,R14,R15} of the previous result, with R0 as the top byte. If that value is zero, `challenge` is sent instead.
- R5: One start produces exactly 14 engine requests.
- R6: `key_out[8i+7:8i]` = R(4+i) xor R(8+i) for i=0..3, taken from result 2. Key bytes 4..7 use the same pairs, taken from result 3.
- R7: Results 4..13 each append six mask bytes, R(2+j) xor R(8+j) for j=0..5. Result 14 appends five. Mask bits are numbered MSB first across the bytes. Transmit bit i is mask bit i, so transmit bit 259 is bit 4 of R4^R10 from result 9. Receive bit i is mask bit 260+i, so receive bit 0 is bit 3 of that same byte and receive bit 259 is bit 0 of R6^R12 from result 14.
- R8: `mask_valid` rises the cycle after result 14 is accepted and stays high. Until then `tx_bit` and `rx_bit` read 0. After that the mask does not change.
- R9: While a request is not accepted, `eng_req_valid` stays high and the payload stays stable.
- R10: `go` is ignored while `busy` is high and once `mask_valid` is high.
- R11: After reset, `busy`, `mask_valid` and `eng_req_valid` are 0 and `key_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Start pulse |
| orig_mode | input | 1 | Enables the dialed-digit overwrite |
| dial_cnt | input | 3 | Number of dialed digits |
| dial_digits | input | 24 | Dialed digits, last dialed in bits 3:0 |
| post_lfsr | input | 32 | LFSR value after authentication |
| challenge | input | 32 | Fallback value for an all-zero LFSR |
| secret | input | 64 | 64-bit shared secret |
| ident | input | 24 | Identity field |
| serial | input | 32 | Serial number |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine request ready |
| eng_req_load_regs | output | 1 | Engine must load `eng_req_regs` |
| eng_req_rounds | output | 4 | Rounds for this run |
| eng_req_lfsr | output | 32 | LFSR load value |
| eng_req_regs | output | 128 | Initial register bytes |
| eng_rsp_valid | input | 1 | Engine result valid |
| eng_rsp_regs | input | 128 | Engine result register bytes |
| busy | output | 1 | Sequence in progress |
| key_out | output | 64 | Session key |
| mask_valid | output | 1 | Mask complete |
| tx_idx | input | 9 | Transmit mask bit index |
| tx_bit | output | 1 | Transmit mask bit |
| rx_idx | input | 9 | Receive mask bit index |
| rx_bit | output | 1 | Receive mask bit |

## Verification
The assertions check the following on every cycle:
- Requests are held under back-pressure.
- The load flag and round count agree with the run number.
- A nonzero challenge never lets an all-zero LFSR reach the engine.
- The mask reads zero before it is complete, `mask_valid` is sticky, and no result is captured once it is set.

Only the bench scenarios can show the rest, because these depend on actual data values flowing through a modelled engine:
- the byte packing of the first load and the digit overwrite;
- the rolling LFSR values and their zero fallback;
- the key pairs;
- the exact position of the split between the transmit and receive masks.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int NREG        = 16;
  localparam int REG_W       = 8 * NREG;
  localparam int ITERS       = 14;
  localparam int KEY_BYTES   = 8;
  localparam int MASK_BYTES  = 65;
  localparam int MASK_HALF   = 260;
  localparam int MASK_FIRST  = 4;
  localparam int MASK_PER_IT = 6;
  localparam int ROUNDS_INIT = 8;
  localparam int ROUNDS_NEXT = 4;
  localparam int DIGITS      = 6;
  localparam logic [7:0] VERSION_BYTE = 8'hC7;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_t;

  function automatic logic [7:0] rbyte(input logic [REG_W-1:0] r, input int n);
    return r[8*n +: 8];
  endfunction
endpackage

// File: rtl/kms_load_build.sv
module kms_load_build
  import kms_pkg::*;
(
  input  logic              orig_mode,
  input  logic [2:0]        dial_cnt,
  input  logic [4*DIGITS-1:0] dial_digits,
  input  logic [31:0]       post_lfsr,
  input  logic [31:0]       challenge,
  input  logic [63:0]       secret,
  input  logic [23:0]       ident,
  input  logic [31:0]       serial,
  output logic [REG_W-1:0]  init_regs,
  output logic [31:0]       init_lfsr
);
  logic [23:0] id_field;
  logic [31:0] mixed;

  always_comb begin
    id_field = ident;
    for (int k = 0; k < DIGITS; k++) begin
      if (orig_mode && (3'(k) < dial_cnt))
        id_field[4*k +: 4] = dial_digits[4*k +: 4];
    end
  end

  always_comb begin
    init_regs = '0;
    for (int n = 0; n < 8; n++)
      init_regs[8*n +: 8] = secret[63-8*n -: 8];
    init_regs[8*8 +: 8] = VERSION_BYTE;
    for (int n = 0; n < 3; n++)
      init_regs[8*(9+n) +: 8] = id_field[23-8*n -: 8];
    for (int n = 0; n < 4; n++)
      init_regs[8*(12+n) +: 8] = serial[31-8*n -: 8];
  end

  assign mixed     = post_lfsr ^ secret[63:32] ^ secret[31:0];
  assign init_lfsr = (mixed == 32'd0) ? challenge : mixed;
endmodule

// File: rtl/kms_ctrl.sv
module kms_ctrl
  import kms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             mask_valid,
  input  logic [REG_W-1:0] init_regs,
  input  logic [31:0]      init_lfsr,
  input  logic [31:0]      challenge,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_load_regs,
  output logic [3:0]       req_rounds,
  output logic [31:0]      req_lfsr,
  output logic [REG_W-1:0] req_regs,
  input  logic             rsp_valid,
  input  logic [REG_W-1:0] rsp_regs,
  output logic             cap_en,
  output logic [3:0]       cap_iter,
  output logic             busy
);
  localparam int IW = $clog2(ITERS + 1);

  seq_state_t    state;
  logic [IW-1:0] iter;
  logic [31:0]   chal_q;
  logic [31:0]   roll;

  assign roll = {rbyte(rsp_regs, 0), rbyte(rsp_regs, 1),
                 rbyte(rsp_regs, 14), rbyte(rsp_regs, 15)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      iter          <= '0;
      chal_q        <= '0;
      req_lfsr      <= '0;
      req_regs      <= '0;
      req_load_regs <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go && !mask_valid) begin
          iter          <= IW'(1);
          chal_q        <= challenge;
          req_lfsr      <= init_lfsr;
          req_regs      <= init_regs;
          req_load_regs <= 1'b1;
          state         <= S_REQ;
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          req_load_regs <= 1'b0;
          if (iter == IW'(ITERS)) begin
            state <= S_IDLE;
          end else begin
            iter     <= iter + IW'(1);
            req_lfsr <= (roll == 32'd0) ? chal_q : roll;
            state    <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid  = (state == S_REQ);
  assign req_rounds = req_load_regs ? 4'(ROUNDS_INIT) : 4'(ROUNDS_NEXT);
  assign cap_en     = (state == S_WAIT) && rsp_valid;
  assign cap_iter   = 4'(iter);
  assign busy       = (state != S_IDLE);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_lfsr) &&
      $stable(req_regs) && $stable(req_load_regs));
  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (chal_q != 32'd0) |-> req_lfsr != 32'd0);
  // R5
  iter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (iter >= IW'(1)) && (iter <= IW'(ITERS)));
  // R1
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_load_regs == (iter == IW'(1))));
endmodule

// File: rtl/kms_store.sv
module kms_store
  import kms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [3:0]       cap_iter,
  input  logic [REG_W-1:0] cap_regs,
  input  logic [8:0]       tx_idx,
  input  logic [8:0]       rx_idx,
  output logic [8*KEY_BYTES-1:0] key_out,
  output logic             mask_valid,
  output logic             tx_bit,
  output logic             rx_bit
);
  localparam int HALF_K = KEY_BYTES / 2;

  logic [7:0] mbuf [MASK_BYTES];
  logic [9:0] tx_g, rx_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_out    <= '0;
      mask_valid <= 1'b0;
      for (int b = 0; b < MASK_BYTES; b++) mbuf[b] <= '0;
    end else if (cap_en) begin
      if (cap_iter == 4'd2 || cap_iter == 4'd3) begin
        for (int i = 0; i < HALF_K; i++)
          key_out[8*(i + ((cap_iter == 4'd3) ? HALF_K : 0)) +: 8] <=
            rbyte(cap_regs, 4+i) ^ rbyte(cap_regs, 8+i);
      end
      if (cap_iter >= 4'(MASK_FIRST)) begin
        for (int j = 0; j < MASK_PER_IT; j++) begin
          if (MASK_PER_IT*(int'(cap_iter) - MASK_FIRST) + j < MASK_BYTES)
            mbuf[7'(MASK_PER_IT*(int'(cap_iter) - MASK_FIRST) + j)] <=
              rbyte(cap_regs, 2+j) ^ rbyte(cap_regs, 8+j);
        end
      end
      if (cap_iter == 4'(ITERS)) mask_valid <= 1'b1;
    end
  end

  assign tx_g = {1'b0, tx_idx};
  assign rx_g = {1'b0, rx_idx} + 10'(MASK_HALF);

  always_comb begin
    tx_bit = 1'b0;
    rx_bit = 1'b0;
    if (mask_valid && (tx_idx < 9'(MASK_HALF)))
      tx_bit = mbuf[tx_g[9:3]][3'd7 - tx_g[2:0]];
    if (mask_valid && (rx_idx < 9'(MASK_HALF)))
      rx_bit = mbuf[rx_g[9:3]][3'd7 - rx_g[2:0]];
  end

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |=> mask_valid);
  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> !cap_en);
endmodule

// File: rtl/kms_top.sv
module kms_top
  import kms_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         orig_mode,
  input  logic [2:0]   dial_cnt,
  input  logic [23:0]  dial_digits,
  input  logic [31:0]  post_lfsr,
  input  logic [31:0]  challenge,
  input  logic [63:0]  secret,
  input  logic [23:0]  ident,
  input  logic [31:0]  serial,
  output logic         eng_req_valid,
  input  logic         eng_req_ready,
  output logic         eng_req_load_regs,
  output logic [3:0]   eng_req_rounds,
  output logic [31:0]  eng_req_lfsr,
  output logic [127:0] eng_req_regs,
  input  logic         eng_rsp_valid,
  input  logic [127:0] eng_rsp_regs,
  output logic         busy,
  output logic [63:0]  key_out,
  output logic         mask_valid,
  input  logic [8:0]   tx_idx,
  output logic         tx_bit,
  input  logic [8:0]   rx_idx,
  output logic         rx_bit
);
  logic [REG_W-1:0] init_regs;
  logic [31:0]      init_lfsr;
  logic             cap_en;
  logic [3:0]       cap_iter;

  kms_load_build u_build (
    .orig_mode(orig_mode), .dial_cnt(dial_cnt), .dial_digits(dial_digits),
    .post_lfsr(post_lfsr), .challenge(challenge), .secret(secret),
    .ident(ident), .serial(serial), .init_regs(init_regs), .init_lfsr(init_lfsr)
  );

  kms_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .mask_valid(mask_valid),
    .init_regs(init_regs), .init_lfsr(init_lfsr), .challenge(challenge),
    .req_valid(eng_req_valid), .req_ready(eng_req_ready),
    .req_load_regs(eng_req_load_regs), .req_rounds(eng_req_rounds),
    .req_lfsr(eng_req_lfsr), .req_regs(eng_req_regs),
    .rsp_valid(eng_rsp_valid), .rsp_regs(eng_rsp_regs),
    .cap_en(cap_en), .cap_iter(cap_iter), .busy(busy)
  );

  kms_store u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_iter(cap_iter),
    .cap_regs(eng_rsp_regs), .tx_idx(tx_idx), .rx_idx(rx_idx),
    .key_out(key_out), .mask_valid(mask_valid), .tx_bit(tx_bit), .rx_bit(rx_bit)
  );

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_valid |-> !tx_bit && !rx_bit);
endmodule

// File: tb/tb_kms_top.sv
module tb_kms_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, orig_mode = 1'b0;
  logic [2:0] dial_cnt = '0;
  logic [23:0] dial_digits = '0, ident = '0;
  logic [31:0] post_lfsr = '0, challenge = '0, serial = '0;
  logic [63:0] secret = '0;
  logic eng_req_valid, eng_req_ready = 1'b0, eng_req_load_regs;
  logic [3:0] eng_req_rounds;
  logic [31:0] eng_req_lfsr;
  logic [127:0] eng_req_regs, eng_rsp_regs = '0;
  logic eng_rsp_valid = 1'b0;
  logic busy, mask_valid, tx_bit, rx_bit;
  logic [63:0] key_out;
  logic [8:0] tx_idx = '0, rx_idx = '0;

  always #5 clk = ~clk;

  kms_top dut (.*);

  int tests = 0, fails = 0;
  // engine stand-in and request log
  int req_cnt = 0, e_state = 0, e_cnt = 0;
  bit mix_mode = 1'b1;
  logic [127:0] e_regs, first_regs;
  logic [31:0] log_lfsr [1:14];
  logic log_ld [1:14];
  logic [3:0] log_rounds [1:14];
  // expected values
  logic [31:0] x_lfsr [1:14];
  logic [63:0] x_key;
  logic [519:0] x_mask;
  logic [127:0] x_init, x_r9, x_r14;

  function automatic logic [7:0] rb(input logic [127:0] r, input int n);
    return r[8*n +: 8];
  endfunction

  function automatic logic [127:0] eng_mix(input logic [127:0] r, input logic [31:0] lf, input int rounds);
    for (int rr = 0; rr < rounds; rr++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] nb;
        nb = r[8*((k+1)%16) +: 8];
        r[8*k +: 8] = (r[8*k +: 8] + {nb[6:0], nb[7]}) ^ lf[7:0];
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      end
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_req_ready = 1'b0; eng_rsp_valid = 1'b0; e_state = 0;
    end else begin
      case (e_state)
        0: begin
          eng_rsp_valid = 1'b0;
          if (eng_req_valid) begin e_cnt = req_cnt % 3; e_state = 1; end
        end
        1: if (e_cnt == 0) begin
          eng_req_ready = 1'b1;
          req_cnt++;
          if (req_cnt <= 14) begin
            log_lfsr[req_cnt] = eng_req_lfsr;
            log_ld[req_cnt] = eng_req_load_regs;
            log_rounds[req_cnt] = eng_req_rounds;
          end
          if (req_cnt == 1) first_regs = eng_req_regs;
          if (eng_req_load_regs) e_regs = eng_req_regs;
          if (mix_mode) e_regs = eng_mix(e_regs, eng_req_lfsr, int'(eng_req_rounds));
          e_state = 2;
        end else e_cnt--;
        2: begin eng_req_ready = 1'b0; e_cnt = 2; e_state = 3; end
        default: if (e_cnt == 0) begin
          eng_rsp_valid = 1'b1; eng_rsp_regs = e_regs; e_state = 0;
        end else e_cnt--;
      endcase
    end
  end

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference sequence built from the requirements
  task automatic compute_expected();
    logic [23:0] fld;
    logic [127:0] r;
    logic [31:0] lf, roll;
    int mb;
    fld = ident;
    if (orig_mode)
      for (int k = 0; k < 6; k++) if (k < int'(dial_cnt)) fld[4*k +: 4] = dial_digits[4*k +: 4];
    x_init = '0;
    for (int n = 0; n < 8; n++) x_init[8*n +: 8] = secret[63-8*n -: 8];
    x_init[71:64] = 8'hC7;
    x_init[79:72] = fld[23:16]; x_init[87:80] = fld[15:8]; x_init[95:88] = fld[7:0];
    x_init[103:96] = serial[31:24]; x_init[111:104] = serial[23:16];
    x_init[119:112] = serial[15:8]; x_init[127:120] = serial[7:0];
    lf = post_lfsr ^ secret[63:32] ^ secret[31:0];
    if (lf == 0) lf = challenge;
    r = x_init; mb = 0; x_mask = '0; x_key = '0;
    for (int it = 1; it <= 14; it++) begin
      x_lfsr[it] = lf;
      if (mix_mode) r = eng_mix(r, lf, (it == 1) ? 8 : 4);
      if (it == 2) for (int i = 0; i < 4; i++) x_key[8*i +: 8] = rb(r, 4+i) ^ rb(r, 8+i);
      if (it == 3) for (int i = 0; i < 4; i++) x_key[8*(4+i) +: 8] = rb(r, 4+i) ^ rb(r, 8+i);
      if (it >= 4)
        for (int j = 0; j < 6; j++)
          if (mb < 65) begin x_mask[519-8*mb -: 8] = rb(r, 2+j) ^ rb(r, 8+j); mb++; end
      if (it == 9) x_r9 = r;
      if (it == 14) x_r14 = r;
      roll = {rb(r, 0), rb(r, 1), rb(r, 14), rb(r, 15)};
      lf = (roll == 0) ? challenge : roll;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; go = 1'b0;
    repeat (3) @(negedge clk);
    req_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_valid();
    for (int c = 0; c < 2000 && !mask_valid; c++) @(negedge clk);
  endtask

  task automatic read_bits(input int i, output logic t, output logic r);
    @(negedge clk); tx_idx = 9'(i); rx_idx = 9'(i);
    #1; t = tx_bit; r = rx_bit;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11", "busy/valid/req", {busy, mask_valid, eng_req_valid}, 0);
    check("R11", "key", key_out, 0);
  endtask

  task automatic t_normal();
    logic t, r;
    logic [259:0] tx_all, rx_all;
    int one_idx = 0;
    bit lf_ok = 1'b1, rd_ok = 1'b1;
    mix_mode = 1'b1; orig_mode = 1'b0;
    dial_cnt = 3'd5; dial_digits = 24'h987654;
    secret = 64'h0123_4567_89AB_CDEF; post_lfsr = 32'h5A5A_1234;
    challenge = 32'hC0FF_EE01; ident = 24'h3C_A5_71; serial = 32'hDEAD_BEEF;
    compute_expected();
    do_reset();
    pulse_go();
    while (req_cnt < 3) @(negedge clk);
    pulse_go(); // R10: start while busy
    while (req_cnt < 14) @(negedge clk);
    for (int i = 0; i < 260; i++) if (x_mask[519-i]) begin one_idx = i; break; end
    @(negedge clk); tx_idx = 9'(one_idx); #1;
    check("R8", "tx bit before completion", {mask_valid, tx_bit}, 0);
    wait_valid();
    repeat (10) @(negedge clk);
    check("R8", "mask_valid after run", mask_valid, 1);
    check("R1", "first regs", first_regs, x_init);
    check("R3", "orig_mode=0 digits ignored", first_regs[95:72], ident[7:0] == 0 ? 0 : {ident[7:0], ident[15:8], ident[23:16]});
    check("R1", "first lfsr", log_lfsr[1], x_lfsr[1]);
    check("R1", "first ld/rounds", {log_ld[1], log_rounds[1]}, {1'b1, 4'd8});
    for (int it = 2; it <= 14; it++)
      if (log_lfsr[it] !== x_lfsr[it] || log_ld[it] !== 1'b0 || log_rounds[it] !== 4'd4) lf_ok = 1'b0;
    check("R4", "rolling lfsr/ld/rounds", lf_ok, 1);
    check("R5", "request count", req_cnt, 14);
    check("R6", "key", key_out, x_key);
    for (int i = 0; i < 260; i++) begin
      read_bits(i, t, r); tx_all[259-i] = t; rx_all[259-i] = r;
    end
    check("R7", "tx mask", tx_all, x_mask[519:260]);
    check("R7", "rx mask", rx_all, x_mask[259:0]);
    read_bits(259, t, r);
    check("R7", "tx last bit", t, (rb(x_r9, 4) ^ rb(x_r9, 10)) >> 4 & 1);
    read_bits(0, t, r);
    check("R7", "rx first bit", r, (rb(x_r9, 4) ^ rb(x_r9, 10)) >> 3 & 1);
    read_bits(259, t, r);
    check("R7", "rx last bit", r, (rb(x_r14, 6) ^ rb(x_r14, 12)) & 1);
    // R10: start after completion is ignored, mask frozen
    pulse_go();
    repeat (30) @(negedge clk);
    check("R10", "no restart after done", {busy, 5'(req_cnt)}, {1'b0, 5'd14});
    for (int i = 0; i < 260; i += 37) begin
      read_bits(i, t, r);
      if (t !== x_mask[519-i] || r !== x_mask[259-i]) rd_ok = 1'b0;
    end
    check("R8", "mask unchanged after go", rd_ok, 1);
  endtask

  task automatic t_zero();
    mix_mode = 1'b0; orig_mode = 1'b0;
    secret = 64'h0000_1234_0000_1234; post_lfsr = 32'h0;
    challenge = 32'h1357_9BDF; ident = 24'h11_22_33; serial = 32'hABCD_0000;
    compute_expected();
    do_reset();
    pulse_go();
    wait_valid();
    repeat (5) @(negedge clk);
    check("R2", "first lfsr fallback", log_lfsr[1], 32'h1357_9BDF);
    check("R4", "rolling fallback", log_lfsr[2], 32'h1357_9BDF);
    check("R6", "key in pass mode", key_out, x_key);
  endtask

  task automatic t_orig();
    mix_mode = 1'b1; orig_mode = 1'b1;
    dial_cnt = 3'd4; dial_digits = 24'hFE_4321;
    secret = 64'hFEDC_BA98_7654_3210; post_lfsr = 32'h0BAD_F00D;
    challenge = 32'h2468_ACE0; ident = 24'hAB_CD_EF; serial = 32'h0102_0304;
    compute_expected();
    do_reset();
    pulse_go();
    wait_valid();
    repeat (5) @(negedge clk);
    check("R3", "R9..R11 with 4 digits", first_regs[95:72], {8'h21, 8'h43, 8'hAB});
    check("R3", "key with digits", key_out, x_key);
    dial_cnt = 3'd7; dial_digits = 24'h65_4321;
    do_reset();
    pulse_go();
    wait_valid();
    check("R3", "count clamps at 6", first_regs[95:72], {8'h21, 8'h43, 8'h65});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_zero();
    t_orig();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule